// File: doc/BRIEF.md
# Dual-Protocol Serial Programming Engine

This block is the host side of a serial programming link. It owns three output wires (serial clock, mode/select and data out) and one return data line. The same wires carry either a boundary-scan (JTAG) stream, with the mode wire as TMS, or an SPI master stream, with the mode wire as an active-low slave select. A command gives a bit count, one value for the mode/select wire and up to `MAX_BITS` outgoing bits. The block shifts them out LSB first and returns the bits it captured, also LSB first.

The serial clock comes from a six-step ladder of half-periods. Each step doubles the one before it, starting at `HALF_MIN` system clocks. Outgoing bits are launched on falling serial edges. The return line is sampled a programmable number of system clocks after each rising edge, which leaves room for the round trip through the target. The three drivers are enabled only while a command runs. Before they are released to high impedance they are driven high. They drop at once if the target supply is reported missing.

Top module: `sps_engine`

## Requirements
- R1: The rate setting k (0 to 5) gives a serial half-period of `HALF_MIN << k` system clocks, so each step halves the serial frequency. A written value above 5 is stored as 5. `rate_o` reports the stored setting.
- R2: After reset the rate setting is 2, the mode is JTAG (`spi_o`=0), `ser_oe_o`=0, `busy_o`=0, `done_o`=0 and `result_o`=0.
- R3: An accepted command first spends one half-period with the clock, data and select driven to 1. Then, for each bit in turn, a falling serial edge launches data bit i (bit 0 first) together with the select value. The clock stays low for one half-period and high for one half-period. While bits are being shifted, data and select change only at falling serial edges.
- R4: During each high phase the return line is sampled at the (D+1)-th system clock edge after the edge that raised the serial clock. D is the effective capture delay.
- R5: The effective delay D is `cap_dly_i` clamped to the half-period minus one.
- R6: During the bits, the select wire carries `cmd_sel_i` in JTAG mode and its inverse in SPI mode. This makes `cmd_sel_i`=1 drive an active-low select to 0.
- R7: After the last high phase the clock stays high. Data and select are driven to 1 for one half-period, and then all three drivers are released together as `busy_o` falls. A full command keeps `busy_o` high for `half*(2*len+2)` system clocks.
- R8: While `tgt_present_i` is 0, `ser_oe_o` is 0 in the same cycle. A running command is abandoned at the next edge without a done pulse, and new commands are ignored.
- R9: A mode or rate write while `busy_o` is 1 is ignored, and `cfg_err_o` is 1 for the single cycle after that edge. A write while idle takes effect at the edge.
- R10: `done_o` is high for exactly one cycle, the cycle after the capture of the last bit. `result_o` bit i then holds the bit sampled in high phase i, and the bits at and above the length are 0.
- R11: A command whose length is 0 or greater than `MAX_BITS` is ignored (`busy_o` stays 0).
- R12: Whenever no command is running, all three bits of `ser_oe_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_present_i | input | 1 | Target supply detected |
| mode_wr_i | input | 1 | Write the mode setting |
| mode_spi_i | input | 1 | Mode to write: 1 = SPI, 0 = JTAG |
| rate_wr_i | input | 1 | Write the rate setting |
| rate_sel_i | input | 3 | Rate setting to write (0 fastest) |
| cap_dly_i | input | 8 | Capture delay in system clocks |
| cmd_valid_i | input | 1 | Start a command (sampled while idle) |
| cmd_len_i | input | 6 | Number of bits to shift |
| cmd_sel_i | input | 1 | TMS value, or select-asserted flag in SPI |
| cmd_data_i | input | 32 | Outgoing bits, bit 0 first |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Captured bits, bit 0 first |
| cfg_err_o | output | 1 | Write while busy was dropped |
| spi_o | output | 1 | Current mode (1 = SPI) |
| rate_o | output | 3 | Current rate setting |
| ser_clk_o | output | 1 | Serial clock (TCK / SCK) |
| ser_sel_o | output | 1 | TMS / active-low SS |
| ser_dout_o | output | 1 | TDI / MOSI |
| ser_oe_o | output | 3 | Driver enables {clock, select, data} |
| ser_din_i | input | 1 | TDO / MISO |

## Verification
The `busy_o` output rises at the edge that samples `cmd_valid_i` and stays high for exactly `half*(2*len+2)` system clocks. Each capture lands D+1 system clocks after the edge that raised the serial clock. The bench plays the target. It changes the return line on the falling half of the system clock, using a counter of high-phase cycles, so moving its threshold by one shows whether sampling happened at cycle D+1 or later. It checks `done_o` and `result_o` one cycle after the final capture and `cfg_err_o` one cycle after the ignored write. It checks `ser_oe_o` in the same cycle as a target drop and `busy_o` one edge later. All sampling happens at the falling system clock edge, half a cycle after the registers settle.

// File: rtl/sps_pkg.sv
package sps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_PARK
    } sps_state_e;

endpackage

// File: rtl/sps_cfg.sv
module sps_cfg #(
    parameter int HALF_MIN  = 2,
    parameter int NUM_RATES = 6,
    parameter int RATE_DEF  = 2,
    localparam int RATE_W   = $clog2(NUM_RATES),
    localparam int HALF_W   = $clog2(HALF_MIN << (NUM_RATES - 1)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy_i,
    input  logic              mode_wr_i,
    input  logic              mode_spi_i,
    input  logic              rate_wr_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    output logic              spi_o,
    output logic [RATE_W-1:0] rate_o,
    output logic [HALF_W-1:0] half_o,
    output logic              cfg_err_o
);

    localparam logic [RATE_W-1:0] RATE_TOP = RATE_W'(NUM_RATES - 1);

    typedef struct packed {
        logic              spi;
        logic [RATE_W-1:0] rate;
        logic              err;
    } cfg_t;

    cfg_t q, n;

    always_comb begin
        n     = q;
        n.err = busy_i & (mode_wr_i | rate_wr_i);
        if (!busy_i) begin
            if (mode_wr_i) n.spi = mode_spi_i;
            if (rate_wr_i) n.rate = (rate_sel_i > RATE_TOP) ? RATE_TOP : rate_sel_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.spi  <= 1'b0;
            q.rate <= RATE_W'(RATE_DEF);
            q.err  <= 1'b0;
        end else begin
            q <= n;
        end
    end

    assign spi_o     = q.spi;
    assign rate_o    = q.rate;
    assign cfg_err_o = q.err;
    assign half_o    = HALF_W'(HALF_MIN) << q.rate;

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(q.spi) && $stable(q.rate))); // R9

endmodule

// File: rtl/sps_dly_clamp.sv
module sps_dly_clamp #(
    parameter int DLY_W  = 8,
    parameter int HALF_W = 7,
    localparam int CW    = (DLY_W > HALF_W) ? DLY_W : HALF_W
) (
    input  logic [DLY_W-1:0]  dly_i,
    input  logic [HALF_W-1:0] half_i,
    output logic [HALF_W-1:0] dly_o
);

    logic [CW-1:0] d_ext;
    logic [CW-1:0] h_ext;

    assign d_ext = CW'(dly_i);
    assign h_ext = CW'(half_i);

    always_comb begin
        if (d_ext >= h_ext) dly_o = HALF_W'(h_ext - CW'(1));
        else                dly_o = HALF_W'(d_ext);
    end

endmodule

// File: rtl/sps_engine.sv
module sps_engine
    import sps_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int HALF_MIN  = 2,
    parameter int NUM_RATES = 6,
    parameter int RATE_DEF  = 2,
    parameter int DLY_W     = 8,
    localparam int LEN_W    = $clog2(MAX_BITS + 1),
    localparam int IDX_W    = $clog2(MAX_BITS),
    localparam int RATE_W   = $clog2(NUM_RATES),
    localparam int HALF_W   = $clog2(HALF_MIN << (NUM_RATES - 1)) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tgt_present_i,
    input  logic                mode_wr_i,
    input  logic                mode_spi_i,
    input  logic                rate_wr_i,
    input  logic [RATE_W-1:0]   rate_sel_i,
    input  logic [DLY_W-1:0]    cap_dly_i,
    input  logic                cmd_valid_i,
    input  logic [LEN_W-1:0]    cmd_len_i,
    input  logic                cmd_sel_i,
    input  logic [MAX_BITS-1:0] cmd_data_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MAX_BITS-1:0] result_o,
    output logic                cfg_err_o,
    output logic                spi_o,
    output logic [RATE_W-1:0]   rate_o,
    output logic                ser_clk_o,
    output logic                ser_sel_o,
    output logic                ser_dout_o,
    output logic [2:0]          ser_oe_o,
    input  logic                ser_din_i
);

    typedef struct packed {
        sps_state_e          st;
        logic [HALF_W-1:0]   hcnt;
        logic [IDX_W-1:0]    idx;
        logic [IDX_W-1:0]    last;
        logic [MAX_BITS-1:0] data;
        logic [MAX_BITS-1:0] res;
        logic                selv;
        logic                sclk;
        logic                dout;
        logic                sel;
        logic                oe;
        logic                done;
    } eng_t;

    eng_t q, n;

    logic [HALF_W-1:0] half;
    logic [HALF_W-1:0] half_m1;
    logic [HALF_W-1:0] dly_eff;
    logic              len_ok;
    logic              bit_sel;
    logic              busy;

    assign busy = (q.st != ST_IDLE);

    sps_cfg #(
        .HALF_MIN  (HALF_MIN),
        .NUM_RATES (NUM_RATES),
        .RATE_DEF  (RATE_DEF)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy),
        .mode_wr_i  (mode_wr_i),
        .mode_spi_i (mode_spi_i),
        .rate_wr_i  (rate_wr_i),
        .rate_sel_i (rate_sel_i),
        .spi_o      (spi_o),
        .rate_o     (rate_o),
        .half_o     (half),
        .cfg_err_o  (cfg_err_o)
    );

    sps_dly_clamp #(
        .DLY_W  (DLY_W),
        .HALF_W (HALF_W)
    ) u_clamp (
        .dly_i  (cap_dly_i),
        .half_i (half),
        .dly_o  (dly_eff)
    );

    assign half_m1 = half - HALF_W'(1);
    assign len_ok  = (cmd_len_i != '0) && (cmd_len_i <= LEN_W'(MAX_BITS));
    assign bit_sel = spi_o ? ~q.selv : q.selv;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                n.oe = 1'b0;
                if (cmd_valid_i && tgt_present_i && len_ok) begin
                    n.st   = ST_LEAD;
                    n.oe   = 1'b1;
                    n.sclk = 1'b1;
                    n.dout = 1'b1;
                    n.sel  = 1'b1;
                    n.hcnt = '0;
                    n.idx  = '0;
                    n.last = IDX_W'(cmd_len_i - LEN_W'(1));
                    n.data = cmd_data_i;
                    n.selv = cmd_sel_i;
                    n.res  = '0;
                end
            end
            ST_LEAD: begin
                if (q.hcnt == half_m1) begin
                    n.st   = ST_LOW;
                    n.hcnt = '0;
                    n.sclk = 1'b0;
                    n.dout = q.data[0];
                    n.sel  = bit_sel;
                end else begin
                    n.hcnt = q.hcnt + HALF_W'(1);
                end
            end
            ST_LOW: begin
                if (q.hcnt == half_m1) begin
                    n.st   = ST_HIGH;
                    n.hcnt = '0;
                    n.sclk = 1'b1;
                end else begin
                    n.hcnt = q.hcnt + HALF_W'(1);
                end
            end
            ST_HIGH: begin
                if (q.hcnt == dly_eff) begin
                    n.res[q.idx] = ser_din_i;
                    n.done       = (q.idx == q.last);
                end
                if (q.hcnt == half_m1) begin
                    n.hcnt = '0;
                    if (q.idx == q.last) begin
                        n.st   = ST_PARK;
                        n.dout = 1'b1;
                        n.sel  = 1'b1;
                    end else begin
                        n.st   = ST_LOW;
                        n.sclk = 1'b0;
                        n.idx  = q.idx + IDX_W'(1);
                        n.data = q.data >> 1;
                        n.dout = q.data[1];
                    end
                end else begin
                    n.hcnt = q.hcnt + HALF_W'(1);
                end
            end
            ST_PARK: begin
                if (q.hcnt == half_m1) begin
                    n.st = ST_IDLE;
                    n.oe = 1'b0;
                end else begin
                    n.hcnt = q.hcnt + HALF_W'(1);
                end
            end
            default: n.st = ST_IDLE;
        endcase
        if (!tgt_present_i) begin
            n.st   = ST_IDLE;
            n.oe   = 1'b0;
            n.done = 1'b0;
            n.sclk = 1'b1;
            n.dout = 1'b1;
            n.sel  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.sclk <= 1'b1;
            q.dout <= 1'b1;
            q.sel  <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign busy_o     = busy;
    assign done_o     = q.done;
    assign result_o   = q.res;
    assign ser_clk_o  = q.sclk;
    assign ser_sel_o  = q.sel;
    assign ser_dout_o = q.dout;
    assign ser_oe_o   = {3{q.oe & tgt_present_i}};

    AST_ABORT_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        !tgt_present_i |=> !busy_o); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_CAPTURE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ser_clk_o); // R4

    AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_LOW || q.st == ST_HIGH) &&
         ($past(q.st) == ST_LOW || $past(q.st) == ST_HIGH) &&
         (q.dout != $past(q.dout) || q.sel != $past(q.sel))) |-> $fell(q.sclk)); // R3

    AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(q.oe) && $past(tgt_present_i)) |-> $past(q.sclk && q.dout && q.sel)); // R7

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ser_oe_o == 3'b000)); // R12

endmodule

// File: tb/tb_sps_engine.sv
module tb_sps_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tgt = 1'b1;
    logic        mode_wr = 1'b0, mode_spi = 1'b0, rate_wr = 1'b0;
    logic [2:0]  rate_sel = 3'd0;
    logic [7:0]  cap_dly = 8'd0;
    logic        cmd_valid = 1'b0;
    logic [5:0]  cmd_len = 6'd0;
    logic        cmd_sel = 1'b0;
    logic [31:0] cmd_data = 32'd0;
    logic        busy, done, cfg_err, spi, sclk, ssel, sdout, sdin;
    logic [31:0] result;
    logic [2:0]  rate, oe;

    int tests = 0, fails = 0;

    always #4 clk = ~clk;

    sps_engine dut (
        .clk(clk), .rst_n(rst_n), .tgt_present_i(tgt),
        .mode_wr_i(mode_wr), .mode_spi_i(mode_spi),
        .rate_wr_i(rate_wr), .rate_sel_i(rate_sel), .cap_dly_i(cap_dly),
        .cmd_valid_i(cmd_valid), .cmd_len_i(cmd_len), .cmd_sel_i(cmd_sel),
        .cmd_data_i(cmd_data), .busy_o(busy), .done_o(done), .result_o(result),
        .cfg_err_o(cfg_err), .spi_o(spi), .rate_o(rate),
        .ser_clk_o(sclk), .ser_sel_o(ssel), .ser_dout_o(sdout),
        .ser_oe_o(oe), .ser_din_i(sdin)
    );

    // Target model and line monitor, all at the falling system edge
    int          rises = 0, r0 = 0, done_cnt = 0, viol = 0, relbad = 0;
    int          hrun = 0, hwidth = 0, hcyc = 0, thr = 0, tail_len = 0;
    logic        dly_mode = 1'b0;
    logic [63:0] pat = 64'd0;
    logic [1023:0] dout_rec = '0, sel_rec = '0;
    logic        p_clk = 1'b1, p_dout = 1'b1, p_sel = 1'b1, p_oe = 1'b0;

    initial sdin = 1'b0;

    always @(negedge clk) begin
        if (done) done_cnt++;
        if (p_oe && oe[0] && (sdout != p_dout || ssel != p_sel) &&
            !(p_clk && !sclk) && (rises - r0) != tail_len) viol++;
        if (p_oe && !oe[0] && tgt && !(p_clk && p_dout && p_sel)) relbad++;
        if (sclk && oe[0]) hrun++;
        else begin
            if (p_clk && !sclk) hwidth = hrun;
            hrun = 0;
        end
        if (sclk) hcyc++; else hcyc = 0;
        if (oe[0] && !p_clk && sclk) begin
            dout_rec[rises % 1024] = sdout;
            sel_rec[rises % 1024]  = ssel;
            if (!dly_mode) sdin = pat[(rises - r0) % 64];
            rises++;
        end
        if (dly_mode) sdin = (hcyc > thr);
        p_clk = sclk; p_dout = sdout; p_sel = ssel; p_oe = oe[0];
    end

    task automatic chk(input logic ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic wm, input logic ms, input logic wr,
                             input logic [2:0] rs);
        @(negedge clk);
        mode_wr = wm; mode_spi = ms; rate_wr = wr; rate_sel = rs;
        @(negedge clk);
        mode_wr = 1'b0; rate_wr = 1'b0;
    endtask

    // Issues a command and waits for busy to fall; returns busy cycles
    task automatic run_cmd(input int len, input logic [31:0] data, input logic sv,
                           output int cyc);
        @(negedge clk);
        r0 = rises; tail_len = len;
        cmd_valid = 1'b1; cmd_len = 6'(len); cmd_data = data; cmd_sel = sv;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk(oe == 3'b000 && !busy && !done, "R2 outputs after reset", {oe, busy, done}, 0);
        chk(rate == 3'd2 && !spi, "R2 rate/mode after reset", {rate, spi}, {3'd2, 1'b0});
        chk(result == 32'd0, "R2 result after reset", result, 0);
    endtask

    task automatic t_jtag_basic;
        int cyc, d0, v0, rb0;
        logic ok;
        d0 = done_cnt; v0 = viol; rb0 = relbad;
        pat = 64'h0000_0000_0000_003C; cap_dly = 8'd2;
        run_cmd(8, 32'h0000_00A5, 1'b1, cyc);
        chk(cyc == 8 * 18, "R7 busy length jtag", cyc, 8 * 18);
        ok = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (dout_rec[(r0 + i) % 1024] != cmd_data[i]) ok = 1'b0;
            if (sel_rec[(r0 + i) % 1024] != 1'b1) ok = 1'b0;
        end
        chk(ok, "R3 data bits LSB first, TMS held (R6)", 0, 0);
        chk(result == 32'h3C, "R10 result LSB first", result, 32'h3C);
        chk(done_cnt - d0 == 1, "R10 single done pulse", done_cnt - d0, 1);
        chk(viol == v0, "R3 launch only on falling edge", viol - v0, 0);
        chk(relbad == rb0, "R7 driven high before release", relbad - rb0, 0);
        chk(oe == 3'b000, "R12 released when idle", oe, 0);
        chk(hwidth == 8, "R1 default half period", hwidth, 8);
    endtask

    task automatic t_spi;
        int cyc;
        logic ok;
        write_cfg(1'b1, 1'b1, 1'b0, 3'd0);
        chk(spi == 1'b1, "R9 mode write while idle", spi, 1);
        pat = 64'h0000_0000_0000_0A5F; cap_dly = 8'd0;
        run_cmd(12, 32'h0000_0C3A, 1'b1, cyc);
        ok = 1'b1;
        for (int i = 0; i < 12; i++) begin
            if (dout_rec[(r0 + i) % 1024] != cmd_data[i]) ok = 1'b0;
            if (sel_rec[(r0 + i) % 1024] != 1'b0) ok = 1'b0;
        end
        chk(ok, "R6 SPI select low during bits, MOSI LSB first", 0, 0);
        chk(result == 32'h0A5F, "R10 SPI result", result, 32'h0A5F);
        write_cfg(1'b1, 1'b0, 1'b0, 3'd0);
    endtask

    task automatic t_rates;
        int cyc;
        write_cfg(1'b0, 1'b0, 1'b1, 3'd0);
        run_cmd(2, 32'h1, 1'b0, cyc);
        chk(hwidth == 2 && cyc == 2 * 6, "R1 rate 0 half period", hwidth, 2);
        write_cfg(1'b0, 1'b0, 1'b1, 3'd5);
        run_cmd(2, 32'h2, 1'b0, cyc);
        chk(hwidth == 64 && cyc == 64 * 6, "R1 rate 5 half period", hwidth, 64);
        write_cfg(1'b0, 1'b0, 1'b1, 3'd7);
        chk(rate == 3'd5, "R1 rate clamp", rate, 5);
        write_cfg(1'b0, 1'b0, 1'b1, 3'd2);
    endtask

    task automatic t_delay;
        int cyc;
        dly_mode = 1'b1;
        cap_dly = 8'd3; thr = 3;
        run_cmd(4, 32'h0, 1'b0, cyc);
        chk(result == 32'hF, "R4 sample at D+1 (late line seen)", result, 32'hF);
        thr = 4;
        run_cmd(4, 32'h0, 1'b0, cyc);
        chk(result == 32'h0, "R4 sample not later than D+1", result, 0);
        cap_dly = 8'd200; thr = 7;
        run_cmd(4, 32'h0, 1'b0, cyc);
        chk(result == 32'hF, "R5 clamped delay reaches half-1", result, 32'hF);
        thr = 8;
        run_cmd(4, 32'h0, 1'b0, cyc);
        chk(result == 32'h0, "R5 clamped delay stays inside high phase", result, 0);
        dly_mode = 1'b0; cap_dly = 8'd0;
    endtask

    task automatic t_busy_write;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 6'd8; cmd_data = 32'h55; cmd_sel = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (10) @(negedge clk);
        mode_wr = 1'b1; mode_spi = 1'b1; rate_wr = 1'b1; rate_sel = 3'd0;
        @(negedge clk);
        mode_wr = 1'b0; rate_wr = 1'b0;
        chk(cfg_err == 1'b1, "R9 error pulse after busy write", cfg_err, 1);
        chk(spi == 1'b0 && rate == 3'd2, "R9 write ignored while busy", {spi, rate}, 3'd2);
        @(negedge clk);
        chk(cfg_err == 1'b0, "R9 error pulse one cycle", cfg_err, 0);
        while (busy) @(negedge clk);
    endtask

    task automatic t_target;
        int d0;
        @(negedge clk);
        tgt = 1'b0;
        cmd_valid = 1'b1; cmd_len = 6'd4; cmd_data = 32'h3;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy, "R8 command ignored without target", busy, 0);
        tgt = 1'b1;
        d0 = done_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 6'd16;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (40) @(negedge clk);
        tgt = 1'b0;
        #1;
        chk(oe == 3'b000, "R8 drivers off same cycle", oe, 0);
        @(negedge clk);
        chk(!busy, "R8 aborted at next edge", busy, 0);
        repeat (5) @(negedge clk);
        chk(done_cnt == d0, "R8 no done on abort", done_cnt - d0, 0);
        tgt = 1'b1;
    endtask

    task automatic t_lengths;
        int cyc;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_len = 6'd0;
        @(negedge clk);
        cmd_len = 6'd33;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(!busy, "R11 length 0 and 33 ignored", busy, 0);
        pat = 64'h0000_0000_8000_0001;
        run_cmd(32, 32'hDEAD_BEEF, 1'b0, cyc);
        chk(result == 32'h8000_0001, "R10 full length result", result, 32'h8000_0001);
        chk(cyc == 8 * 66, "R7 full length busy", cyc, 8 * 66);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jtag_basic();
        t_spi();
        t_rates();
        t_delay();
        t_busy_write();
        t_target();
        t_lengths();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        tests++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule